// File: doc/BRIEF.md
# Power Mode and Backup Arbitration Logic

This block sits between the control registers written over the serial port and the enables of a pager power system's analog blocks. It combines register fields with a handful of pins: a run request pin, an audio tone input for the second open-drain driver, the low-battery comparator output and the reset-detector output. From these it decides the effective operating mode. It also gates the PWM and PLL circuits, and it chooses between the boost converter, the battery charger and the backup linear regulator. Finally it drives the two open-drain switch gates, powers the threshold DAC and comparators, and passes on the output-voltage code together with its logic-supply clamp flag.

Nearly every output is a combinational function of the inputs. The one exception is the low-battery flag. That flag can switch the converter off through the automatic backup path, so it first passes through a flop synchroniser. A reset-detector event overrides everything else and puts the block into a safe state: coast mode, converter on, backup off. From there a freshly inserted battery can restart the system.

Top module: `pwr_mode_arb`

## Requirements
- R1: `run_mode` is high when `run_pin` or `reg_run` is high, and low (coast) only when both are low.
- R2: `pwm_en` is low whenever `run_mode` is low, and it is low while the converter is disabled. Otherwise it equals `run_mode`.
- R3: `backup_en` is high when `reg_bkup` is high. It is also high when `reg_auto_bkup` is high and the synchronised low-battery flag is high. A rise of `lowbat_i` reaches `backup_en` at the second rising clock edge after it is applied.
- R4: While `backup_en` is high, `conv_en` is low and `chg_sel` is 00. The driver gates, `sense_en` and `vout_code` are unaffected by backup.
- R5: `chg_sel` encodes the charger current as 00 off, 01 low (1 mA) and 10 high (15 mA). With both `reg_chg_hi` and `reg_chg_lo` set, the result is 10. The value 11 never appears.
- R6: `drv1_on` equals `reg_drv1`. `drv2_on` is high only when `reg_drv2` and `tone_in` are both high.
- R7: `vout_code` carries the selected output voltage, 1.8 V + code × 100 mV. `clamp_en` is high exactly when `vout_code` is 16 (3.4 V) or above.
- R8: Any `reg_vsel` value above 31 gives `vout_code` 31, the 4.9 V setting.
- R9: `sense_en` is low when `reg_dac` is zero and high for any non-zero code.
- R10: While `rsd_n` is low, the block forces a fixed state and ignores all register fields: `run_mode` 0, `pwm_en` 0, `backup_en` 0, `conv_en` 1, `chg_sel` 00, both drivers off, `sense_en` 0 and `vout_code` 12 (3.0 V).
- R11: `lowbat_i` is sampled only at rising clock edges. A pulse that covers no rising edge never triggers backup, and `rst_n` clears the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the low-battery synchroniser |
| rst_n | input | 1 | Asynchronous active-low reset of the synchroniser |
| rsd_n | input | 1 | Reset-detector output, low during a reset event |
| run_pin | input | 1 | External run request |
| tone_in | input | 1 | Audio tone input gated onto driver 2 |
| lowbat_i | input | 1 | Low-battery comparator output, high when battery is low |
| reg_run | input | 1 | Run/coast register bit |
| reg_drv1 | input | 1 | Driver 1 enable bit |
| reg_drv2 | input | 1 | Driver 2 enable bit |
| reg_chg_hi | input | 1 | 15 mA charge request |
| reg_chg_lo | input | 1 | 1 mA charge request |
| reg_bkup | input | 1 | Direct backup command |
| reg_auto_bkup | input | 1 | Arms backup on low battery |
| reg_vsel | input | VSEL_W (6) | Requested output-voltage code |
| reg_dac | input | DAC_W (7) | Threshold DAC code |
| run_mode | output | 1 | Effective run mode (0 = coast) |
| pwm_en | output | 1 | PWM and PLL enable |
| conv_en | output | 1 | Boost converter enable |
| chg_sel | output | 2 | Charger current select |
| backup_en | output | 1 | Backup regulator enable |
| drv1_on | output | 1 | Driver 1 gate |
| drv2_on | output | 1 | Driver 2 gate |
| clamp_en | output | 1 | Logic-supply clamp enable |
| sense_en | output | 1 | Power for DAC, comparators and dividers |
| vout_code | output | VOUT_W (5) | Applied output-voltage code |

## Verification
All outputs except the low-battery path are combinational. The bench therefore applies each table vector at a falling edge and compares the outputs two nanoseconds later, before any rising edge arrives. For a low-battery rise, the automatic backup appears only after the second rising edge. The bench checks that `backup_en` is still low after the first edge and high after the second, each time at the following falling edge. For a pulse placed wholly between two rising edges, the bench checks that backup never fires. A reset-detector event must take effect in the same cycle, so its check samples without waiting for a clock edge.

// File: rtl/pma_pkg.sv
package pma_pkg;
   localparam logic [1:0] CHG_OFF  = 2'b00;
   localparam logic [1:0] CHG_LOW  = 2'b01;
   localparam logic [1:0] CHG_HIGH = 2'b10;
endpackage

// File: rtl/pma_lb_sync.sv
module pma_lb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   initial assert (STAGES >= 2) else $error("pma_lb_sync: STAGES must be at least 2");

   logic [STAGES-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= '0;
      else        st <= {st[STAGES-2:0], d_i};
   end

   assign q_o = st[STAGES-1];

   // R11
   lb_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q_o) |-> $past(st[STAGES-2]));
endmodule

// File: rtl/pma_vout_map.sv
module pma_vout_map #(
   parameter int IN_W       = 6,
   parameter int OUT_W      = 5,
   parameter int CLAMP_CODE = 16
) (
   input  logic [IN_W-1:0]  code_i,
   output logic [OUT_W-1:0] code_o,
   output logic             clamp_o
);
   initial assert (IN_W >= 1 && OUT_W >= 1 && CLAMP_CODE < (1 << OUT_W))
      else $error("pma_vout_map: bad width or clamp code");

   localparam logic [OUT_W-1:0] CLAMP_V = OUT_W'(CLAMP_CODE);

   generate
      if (IN_W > OUT_W) begin : g_sat
         logic over;
         assign over   = |code_i[IN_W-1:OUT_W];
         assign code_o = over ? {OUT_W{1'b1}} : code_i[OUT_W-1:0];
      end else begin : g_pass
         assign code_o = OUT_W'(code_i);
      end
   endgenerate

   assign clamp_o = (code_o >= CLAMP_V);
endmodule

// File: rtl/pma_backup_arb.sv
module pma_backup_arb
   import pma_pkg::*;
(
   input  logic       cmd_i,
   input  logic       auto_i,
   input  logic       lowbat_i,
   input  logic       kill_i,
   input  logic       chg_hi_i,
   input  logic       chg_lo_i,
   output logic       bk_o,
   output logic       conv_o,
   output logic [1:0] chg_o
);
   always_comb begin
      bk_o   = !kill_i && (cmd_i || (auto_i && lowbat_i));
      conv_o = !bk_o;
      if (bk_o || kill_i) chg_o = CHG_OFF;
      else if (chg_hi_i)  chg_o = CHG_HIGH;
      else if (chg_lo_i)  chg_o = CHG_LOW;
      else                chg_o = CHG_OFF;
   end
endmodule

// File: rtl/pwr_mode_arb.sv
module pwr_mode_arb
   import pma_pkg::*;
#(
   parameter int VSEL_W      = 6,
   parameter int VOUT_W      = 5,
   parameter int DAC_W       = 7,
   parameter int CLAMP_CODE  = 16,
   parameter int RST_VCODE   = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rsd_n,
   input  logic              run_pin,
   input  logic              tone_in,
   input  logic              lowbat_i,
   input  logic              reg_run,
   input  logic              reg_drv1,
   input  logic              reg_drv2,
   input  logic              reg_chg_hi,
   input  logic              reg_chg_lo,
   input  logic              reg_bkup,
   input  logic              reg_auto_bkup,
   input  logic [VSEL_W-1:0] reg_vsel,
   input  logic [DAC_W-1:0]  reg_dac,
   output logic              run_mode,
   output logic              pwm_en,
   output logic              conv_en,
   output logic [1:0]        chg_sel,
   output logic              backup_en,
   output logic              drv1_on,
   output logic              drv2_on,
   output logic              clamp_en,
   output logic              sense_en,
   output logic [VOUT_W-1:0] vout_code
);
   initial assert (RST_VCODE < (1 << VOUT_W) && DAC_W >= 1)
      else $error("pwr_mode_arb: reset code does not fit");

   localparam logic [VOUT_W-1:0] RST_V     = VOUT_W'(RST_VCODE);
   localparam logic [VOUT_W-1:0] CLAMP_V   = VOUT_W'(CLAMP_CODE);
   localparam logic              RST_CLAMP = (RST_VCODE >= CLAMP_CODE);

   logic              evt;
   logic              lowbat_s;
   logic [VOUT_W-1:0] vmap;
   logic              vclamp;

   assign evt = !rsd_n;

   pma_lb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (lowbat_i),
      .q_o   (lowbat_s)
   );

   pma_vout_map #(.IN_W(VSEL_W), .OUT_W(VOUT_W), .CLAMP_CODE(CLAMP_CODE)) u_vmap (
      .code_i  (reg_vsel),
      .code_o  (vmap),
      .clamp_o (vclamp)
   );

   pma_backup_arb u_bk (
      .cmd_i    (reg_bkup),
      .auto_i   (reg_auto_bkup),
      .lowbat_i (lowbat_s),
      .kill_i   (evt),
      .chg_hi_i (reg_chg_hi),
      .chg_lo_i (reg_chg_lo),
      .bk_o     (backup_en),
      .conv_o   (conv_en),
      .chg_o    (chg_sel)
   );

   always_comb begin
      run_mode  = !evt && (run_pin || reg_run);
      pwm_en    = run_mode && conv_en;
      drv1_on   = !evt && reg_drv1;
      drv2_on   = !evt && reg_drv2 && tone_in;
      sense_en  = !evt && (|reg_dac);
      vout_code = evt ? RST_V : vmap;
      clamp_en  = evt ? RST_CLAMP : vclamp;
   end

   // R2
   coast_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_mode |-> !pwm_en);

   // R4
   backup_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      backup_en |-> (!conv_en && chg_sel == CHG_OFF && !pwm_en));

   // R5
   chg_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chg_sel));

   // R6
   drv2_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv2_on |-> (tone_in && reg_drv2));

   // R7
   clamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clamp_en |-> (vout_code >= CLAMP_V));

   // R10
   rsd_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsd_n |-> (conv_en && !backup_en && !run_mode && vout_code == RST_V));
endmodule

// File: tb/sim_pwr_mode_arb.sv
module sim_pwr_mode_arb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rsd_n, run_pin, tone_in, lowbat_i, reg_run, reg_drv1, reg_drv2;
   logic reg_chg_hi, reg_chg_lo, reg_bkup, reg_auto_bkup;
   logic [5:0] reg_vsel;
   logic [6:0] reg_dac;
   logic run_mode, pwm_en, conv_en, backup_en, drv1_on, drv2_on, clamp_en, sense_en;
   logic [1:0] chg_sel;
   logic [4:0] vout_code;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pwr_mode_arb u0 (
      .clk(clk), .rst_n(rst_n), .rsd_n(rsd_n), .run_pin(run_pin), .tone_in(tone_in),
      .lowbat_i(lowbat_i), .reg_run(reg_run), .reg_drv1(reg_drv1), .reg_drv2(reg_drv2),
      .reg_chg_hi(reg_chg_hi), .reg_chg_lo(reg_chg_lo), .reg_bkup(reg_bkup),
      .reg_auto_bkup(reg_auto_bkup), .reg_vsel(reg_vsel), .reg_dac(reg_dac),
      .run_mode(run_mode), .pwm_en(pwm_en), .conv_en(conv_en), .chg_sel(chg_sel),
      .backup_en(backup_en), .drv1_on(drv1_on), .drv2_on(drv2_on), .clamp_en(clamp_en),
      .sense_en(sense_en), .vout_code(vout_code)
   );

   // stimulus: {rsd_n,run_pin,tone,reg_run | drv1,drv2,chg_hi,chg_lo | bkup,auto | vsel | dac}
   // expected: {run,pwm,conv | chg_sel | backup,drv1,drv2 | clamp,sense | vout}
   localparam int NV = 10;
   localparam logic [22:0] STIM [NV] = '{
      23'b1000_0000_00_001100_0000000,
      23'b1100_0000_00_001111_0000001,
      23'b1001_0000_00_010000_0000000,
      23'b1000_0011_00_011111_0000000,
      23'b1000_0001_00_101000_0000000,
      23'b1000_1100_00_000000_1111111,
      23'b1010_0100_00_000000_0000000,
      23'b1100_0010_10_001100_0000000,
      23'b0101_1010_10_010100_0000101,
      23'b1000_0000_01_001100_0000000
   };
   localparam logic [14:0] EXPV [NV] = '{
      15'b001_00_000_00_01100,
      15'b111_00_000_01_01111,
      15'b111_00_000_10_10000,
      15'b001_10_000_10_11111,
      15'b001_01_000_10_11111,
      15'b001_00_010_01_00000,
      15'b001_00_001_00_00000,
      15'b100_00_100_00_01100,
      15'b001_00_000_00_01100,
      15'b001_00_000_00_01100
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic apply(input logic [22:0] s);
      {rsd_n, run_pin, tone_in, reg_run, reg_drv1, reg_drv2, reg_chg_hi, reg_chg_lo,
       reg_bkup, reg_auto_bkup, reg_vsel, reg_dac} = s;
   endtask

   task automatic check_vec(input logic [14:0] e);
      chk("R1 run_mode",  8'(run_mode),  8'(e[14]));
      chk("R2 pwm_en",    8'(pwm_en),    8'(e[13]));
      chk("R4 conv_en",   8'(conv_en),   8'(e[12]));
      chk("R5 chg_sel",   8'(chg_sel),   8'(e[11:10]));
      chk("R3 backup_en", 8'(backup_en), 8'(e[9]));
      chk("R6 drv1_on",   8'(drv1_on),   8'(e[8]));
      chk("R6 drv2_on",   8'(drv2_on),   8'(e[7]));
      chk("R7 clamp_en",  8'(clamp_en),  8'(e[6]));
      chk("R9 sense_en",  8'(sense_en),  8'(e[5]));
      chk("R8 vout_code", 8'(vout_code), 8'(e[4:0]));
   endtask

   initial begin
      #100000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      lowbat_i = 1'b0;
      apply(STIM[0]);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state: idle registers, no event
      #2 check_vec(EXPV[0]);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         apply(STIM[i]);
         #2 check_vec(EXPV[i]);
      end

      // R10: reset event overrides a backup command and a run request
      @(negedge clk);
      apply(STIM[8]);
      #2 chk("R10 conv forced on", 8'(conv_en), 8'd1);
      chk("R10 backup off", 8'(backup_en), 8'd0);
      chk("R10 vout reset code", 8'(vout_code), 8'd12);

      // R3: armed auto backup, lowbat rise appears after two edges
      @(negedge clk);
      apply(STIM[9]);
      lowbat_i = 1'b1;
      @(negedge clk);
      chk("R3 no backup after one edge", 8'(backup_en), 8'd0);
      @(negedge clk);
      chk("R3 auto backup after two edges", 8'(backup_en), 8'd1);
      chk("R4 converter off in backup", 8'(conv_en), 8'd0);
      // R10: reset event kills automatic backup at once
      rsd_n = 1'b0;
      #2 chk("R10 auto backup killed", 8'(backup_en), 8'd0);
      chk("R10 conv on during event", 8'(conv_en), 8'd1);
      @(negedge clk);
      rsd_n = 1'b1;
      // R3: not armed, low battery has no effect
      reg_auto_bkup = 1'b0;
      repeat (3) @(negedge clk);
      chk("R3 unarmed lowbat ignored", 8'(backup_en), 8'd0);
      chk("R3 unarmed conv stays on", 8'(conv_en), 8'd1);
      lowbat_i = 1'b0;
      reg_auto_bkup = 1'b1;
      repeat (3) @(negedge clk);
      chk("R3 lowbat cleared", 8'(backup_en), 8'd0);

      // R11: short pulse between two rising edges is never sampled
      @(posedge clk);
      #1 lowbat_i = 1'b1;
      #2 lowbat_i = 1'b0;
      @(negedge clk);
      chk("R11 glitch stage1", 8'(backup_en), 8'd0);
      repeat (2) @(negedge clk);
      chk("R11 glitch ignored", 8'(backup_en), 8'd0);

      // R11: rst_n clears the synchroniser
      lowbat_i = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11 armed before reset", 8'(backup_en), 8'd1);
      lowbat_i = 1'b0;
      rst_n = 1'b0;
      #2 chk("R11 rst_n clears sync", 8'(backup_en), 8'd0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule